// File: doc/BRIEF.md
# Paged Fragment Buffer Write Controller

This block receives a stream of words from a readout link and stores the data words of each event fragment in a paged buffer memory. Every word carries a flag that says whether it is a control word or a data word. Control words open and close fragments. Between them, data words fill pages of a programmable length. The base address of every page comes from an external free-page FIFO, which works in show-ahead mode. When a page is finished, the block pushes a descriptor into an external used-page FIFO. The descriptor holds the last address written and two flags that place the page within its fragment.

The block also drives a back-pressure signal toward the sender. The signal is high through reset. It stays high until software sets the enable input and enough free pages are available. If a new page is needed and no free page exists, the block stalls its input.

A data word that arrives outside a fragment is discarded and counted in a saturating error counter.

Top module: `frag_page_writer`

## Requirements
- R1: A word with `in_ctrl`=1 is a control word. If `in_word[1]`=1 it ends the current fragment. Otherwise, if `in_word[0]`=1 it starts a fragment. A control word with both bits clear has no effect on the addresses or descriptors.
- R2: The first data word of a fragment does three things in the cycle it is accepted: it pops the free-page FIFO, it takes `free_base` as the page base, and it is written at that base. Later words of the same page go to consecutive addresses. Each write appears on `mem_we`/`mem_addr`/`mem_wdata` in the cycle after acceptance.
- R3: A page holds `cfg_page_len` words. A data word that arrives when the open page is already full closes that page and opens a new one from the next free entry. The close pushes a descriptor with the page's last address and `used_last`=0.
- R4: An end word closes the open page and pushes a descriptor with its last address and `used_last`=1. `used_first`=1 marks the first page of a fragment, so a single-page fragment sets both flags and an intermediate page sets neither. A fragment with no data pushes nothing.
- R5: A start word that arrives inside a fragment closes the open page as if an end word had arrived, then begins a new fragment.
- R6: A data word that needs a new page while `free_count`=0 sees `in_ready` low and is neither written nor popped. It is accepted once an entry becomes available.
- R7: A data word outside a fragment is accepted and dropped, with no write and no descriptor. It increments `proto_err_cnt`, which saturates at all ones.
- R8: `xoff` is high during reset. After each clock edge, `xoff` is low only if `cfg_enable`=1 and `free_count` was at or above `cfg_xoff_thresh` at that edge.
- R9: `free_pop` is high only in a cycle where a data word needing a new page is accepted, and so only when `free_count` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ctrl | input | 1 | Input word is a control word |
| in_word | input | DATA_W | Input word |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| mem_we | output | 1 | Buffer memory write strobe |
| mem_addr | output | ADDR_W | Buffer memory write address |
| mem_wdata | output | DATA_W | Buffer memory write data |
| free_pop | output | 1 | Consume the head of the free-page FIFO |
| free_base | input | ADDR_W | Head entry of the free-page FIFO |
| free_count | input | CNT_W | Free-page FIFO occupancy |
| used_push | output | 1 | Push a descriptor into the used-page FIFO |
| used_last_addr | output | ADDR_W | Last address written in the closed page |
| used_first | output | 1 | Closed page is the first of its fragment |
| used_last | output | 1 | Closed page is the last of its fragment |
| cfg_page_len | input | LEN_W | Words per page, at least 1 |
| cfg_xoff_thresh | input | CNT_W | Free-page occupancy below which xoff is raised |
| cfg_enable | input | 1 | Allows xoff to drop |
| xoff | output | 1 | Back-pressure request toward the sender |
| proto_err_cnt | output | ERR_W | Saturating count of stray data words |

## Verification
The assertions check several properties on every cycle. Every pop is followed by a write at the popped base. A write never leaves the current page. A last-page descriptor always leaves no page open. A refused word produces no write and no push. `xoff` holds while the enable is low. A saturated error count stays saturated.

Some behaviours need whole sequences of traffic, so only the bench scenarios can show them. These include the exact first/last flag combinations, the deferred close of a page that is exactly full, the implicit close on a second start, and the release of a stall when a free entry arrives.

// File: rtl/frag_page_writer.sv
module frag_page_writer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 6,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_ctrl,
  input  logic [DATA_W-1:0] in_word,
  output logic              in_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              free_pop,
  input  logic [ADDR_W-1:0] free_base,
  input  logic [CNT_W-1:0]  free_count,
  output logic              used_push,
  output logic [ADDR_W-1:0] used_last_addr,
  output logic              used_first,
  output logic              used_last,
  input  logic [LEN_W-1:0]  cfg_page_len,
  input  logic [CNT_W-1:0]  cfg_xoff_thresh,
  input  logic              cfg_enable,
  output logic              xoff,
  output logic [ERR_W-1:0]  proto_err_cnt
);

  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic              in_frag;
  logic              page_open;
  logic              cur_first;
  logic [ADDR_W-1:0] page_base;
  logic [LEN_W-1:0]  wcnt;

  wire is_data   = !in_ctrl;
  wire is_end    = in_ctrl && in_word[1];
  wire is_start  = in_ctrl && !in_word[1] && in_word[0];
  wire full      = wcnt >= cfg_page_len;
  wire need_page = in_frag && is_data && (!page_open || full);
  wire accept;
  wire [ADDR_W-1:0] tail_addr = page_base + ADDR_W'(wcnt) - ADDR_W'(1);

  assign in_ready = !(in_valid && need_page && (free_count == '0));
  assign accept   = in_valid && in_ready;
  assign free_pop = accept && need_page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xoff           <= 1'b1;
      in_frag        <= 1'b0;
      page_open      <= 1'b0;
      cur_first      <= 1'b0;
      page_base      <= '0;
      wcnt           <= '0;
      mem_we         <= 1'b0;
      mem_addr       <= '0;
      mem_wdata      <= '0;
      used_push      <= 1'b0;
      used_last_addr <= '0;
      used_first     <= 1'b0;
      used_last      <= 1'b0;
      proto_err_cnt  <= '0;
    end else begin
      xoff      <= !(cfg_enable && (free_count >= cfg_xoff_thresh));
      mem_we    <= 1'b0;
      used_push <= 1'b0;
      if (accept) begin
        if (is_data) begin
          if (!in_frag) begin
            if (proto_err_cnt != ERR_MAX) proto_err_cnt <= proto_err_cnt + ERR_W'(1);
          end else if (need_page) begin
            if (page_open) begin
              used_push      <= 1'b1;
              used_last_addr <= tail_addr;
              used_first     <= cur_first;
              used_last      <= 1'b0;
            end
            cur_first <= !page_open;
            page_open <= 1'b1;
            page_base <= free_base;
            wcnt      <= LEN_W'(1);
            mem_we    <= 1'b1;
            mem_addr  <= free_base;
            mem_wdata <= in_word;
          end else begin
            mem_we    <= 1'b1;
            mem_addr  <= page_base + ADDR_W'(wcnt);
            mem_wdata <= in_word;
            wcnt      <= wcnt + LEN_W'(1);
          end
        end else if (is_end || is_start) begin
          if (in_frag && page_open) begin
            used_push      <= 1'b1;
            used_last_addr <= tail_addr;
            used_first     <= cur_first;
            used_last      <= 1'b1;
          end
          page_open <= 1'b0;
          in_frag   <= is_start;
        end
      end
    end
  end

  assert_pop_then_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    free_pop |=> (mem_we && mem_addr == $past(free_base)));

  assert_write_in_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_addr - page_base) < ADDR_W'(cfg_page_len)));

  assert_last_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (used_push && used_last) |-> !page_open);

  assert_refused_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (!mem_we && !used_push));

  assert_err_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_err_cnt == ERR_MAX) |=> (proto_err_cnt == ERR_MAX));

  assert_xoff_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_enable) |-> xoff);

endmodule

// File: tb/frag_page_writer_bench.sv
module frag_page_writer_bench;
  localparam int ADDR_W = 16, DATA_W = 32, LEN_W = 8, CNT_W = 6, ERR_W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, in_valid, in_ctrl, in_ready, mem_we, free_pop, used_push, used_first, used_last;
  logic cfg_enable, xoff;
  logic [DATA_W-1:0] in_word, mem_wdata;
  logic [ADDR_W-1:0] mem_addr, free_base, used_last_addr;
  logic [CNT_W-1:0]  free_count, cfg_xoff_thresh;
  logic [LEN_W-1:0]  cfg_page_len;
  logic [ERR_W-1:0]  proto_err_cnt;

  frag_page_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .ERR_W(ERR_W))
  u_frag_page_writer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl), .in_word(in_word),
    .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .free_pop(free_pop), .free_base(free_base), .free_count(free_count),
    .used_push(used_push), .used_last_addr(used_last_addr), .used_first(used_first),
    .used_last(used_last), .cfg_page_len(cfg_page_len), .cfg_xoff_thresh(cfg_xoff_thresh),
    .cfg_enable(cfg_enable), .xoff(xoff), .proto_err_cnt(proto_err_cnt));

  int fq[$];
  int checks = 0, fails = 0;
  string tag = "reset";
  bit last_acc;

  bit m_frag, m_open, m_first, m_xoff;
  int m_base, m_cnt, m_err;
  bit e_we, e_push, e_first, e_last;
  int e_addr, e_la;
  logic [DATA_W-1:0] e_data;

  task automatic refresh();
    free_count = CNT_W'(fq.size());
    free_base  = (fq.size() != 0) ? ADDR_W'(fq[0]) : '0;
  endtask

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h", req, tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic cyc(bit v, bit c, logic [DATA_W-1:0] w);
    bit need, er, ep;
    in_valid = v; in_ctrl = c; in_word = w;
    #1;
    need = m_frag && !c && (!m_open || m_cnt >= int'(cfg_page_len));
    er = !(v && need && fq.size() == 0);
    ep = v && er && need;
    chk("R6", "in_ready", in_ready, er);
    chk("R9", "free_pop", free_pop, ep);
    last_acc = v && er;
    @(posedge clk); #1;
    m_xoff = !(cfg_enable && fq.size() >= int'(cfg_xoff_thresh));
    e_we = 0; e_push = 0;
    if (v && er) begin
      if (!c) begin
        if (!m_frag) begin
          if (m_err < 255) m_err++;
        end else if (need) begin
          if (m_open) begin
            e_push = 1; e_la = m_base + m_cnt - 1; e_first = m_first; e_last = 0;
          end
          m_first = !m_open; m_open = 1; m_base = fq.pop_front(); m_cnt = 1;
          e_we = 1; e_addr = m_base; e_data = w;
          refresh();
        end else begin
          e_we = 1; e_addr = m_base + m_cnt; e_data = w; m_cnt++;
        end
      end else if (w[1] || w[0]) begin
        if (m_frag && m_open) begin
          e_push = 1; e_la = m_base + m_cnt - 1; e_first = m_first; e_last = 1;
        end
        m_open = 0;
        m_frag = !w[1];
      end
    end
    @(negedge clk);
    chk("R8", "xoff", xoff, m_xoff);
    chk("R2", "mem_we", mem_we, e_we);
    if (e_we) begin
      chk("R2", "mem_addr", mem_addr, e_addr & 16'hffff);
      chk("R2", "mem_wdata", mem_wdata, e_data);
    end
    chk("R3", "used_push", used_push, e_push);
    if (e_push) begin
      chk("R4", "used_last_addr", used_last_addr, e_la & 16'hffff);
      chk("R4", "used_first", used_first, e_first);
      chk("R4", "used_last", used_last, e_last);
    end
    chk("R7", "proto_err_cnt", proto_err_cnt, m_err);
  endtask

  task automatic send(bit c, logic [DATA_W-1:0] w);
    for (int k = 0; k < 50; k++) begin
      cyc(1'b1, c, w);
      if (last_acc) break;
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, '0);
  endtask

  task automatic data(int n, int seed);
    for (int k = 0; k < n; k++) send(1'b0, DATA_W'(seed + k));
  endtask

  initial begin
    #4000000;
    checks++; fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; in_valid = 0; in_ctrl = 0; in_word = '0;
    cfg_enable = 0; cfg_xoff_thresh = 6'd2; cfg_page_len = 8'd4;
    for (int k = 1; k <= 20; k++) fq.push_back(k * 256);
    refresh();
    m_frag = 0; m_open = 0; m_first = 0; m_xoff = 1; m_base = 0; m_cnt = 0; m_err = 0;
    #15;
    chk("R8", "xoff in reset", xoff, 1);
    chk("R2", "mem_we in reset", mem_we, 0);
    chk("R3", "used_push in reset", used_push, 0);
    chk("R7", "err in reset", proto_err_cnt, 0);
    @(negedge clk); rst_n = 1;

    tag = "R8 disabled"; idle(2);
    cfg_enable = 1; tag = "R8 enabled"; idle(2);

    tag = "R7 stray data"; data(3, 'hA0);

    tag = "R1 R4 single page"; send(1, 1); data(3, 'h10); send(1, 2); idle(1);
    tag = "R3 three pages"; send(1, 1); data(9, 'h20); send(1, 2);
    tag = "R3 exactly full"; send(1, 1); data(4, 'h40); send(1, 2);
    tag = "R5 restart"; send(1, 1); data(2, 'h50); send(1, 1); data(1, 'h58); send(1, 2);
    tag = "R4 empty fragment"; send(1, 1); send(1, 2); idle(1);
    tag = "R1 neutral control"; send(1, 1); data(1, 'h60); send(1, 4); data(1, 'h61); send(1, 2);
    tag = "R1 end outside"; send(1, 2); idle(1);

    tag = "R6 stall";
    fq.delete(); refresh(); idle(2);
    send(1, 1);
    for (int k = 0; k < 3; k++) cyc(1, 0, 'h70);
    fq.push_back('h9000); fq.push_back('hA000); refresh();
    data(5, 'h70); send(1, 2);
    tag = "R8 refill"; fq.push_back('hB000); refresh(); idle(2);

    tag = "R7 saturation"; data(260, 'h100); idle(1);

    summary();
    $finish;
  end
endmodule